// File: doc/BRIEF.md
# Multi-Frame Phase Clock Generator

This block keeps the local multi-frame timebase of a serial converter link. It counts device-clock cycles as octets, groups them into frames of F octets, and groups frames into multi-frames of K frames. It gives out a strobe on the first octet of every frame and a strobe on the first octet of every multi-frame. Other link logic uses these strobes to schedule its events. Examples are starting transmission after synchronisation and releasing buffered lane data. Such events may happen only on a multi-frame boundary.

The phase of the timebase can be set from outside. With a subclass setting of 1, a rising edge on the reference strobe input moves the counters to zero. The reference strobe may be continuous, gapped or single-shot. With a subclass setting of 2, the release edge of the link synchronisation request does this instead. With a subclass setting of 0, the counters run free from reset. Two flags report the state of the timebase. One shows that the phase has been set. The other records a reference edge that arrived out of step with the running timebase.

Top module: `mf_clock_gen`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it is released, the octet and frame counts are zero: frame_pulse and mf_pulse are 1, and locked and phase_err are 0.
- R2: frame_pulse is 1 on one cycle in every F, where F = cfg_octets_m1 + 1 (F from 1 to 256). With F = 1 it is 1 on every cycle.
- R3: mf_pulse is 1 on one cycle in every F*K, where K = cfg_frames_m1 + 1 (K from 1 to 32). Every mf_pulse falls on a cycle where frame_pulse is also 1.
- R4: With cfg_subclass = 1, suppose a clock edge samples sysref high and the edge before it sampled sysref low. Then the edge is accepted, unless the one-shot rule blocks it. Both counters are zero in the cycle after that clock edge, so frame_pulse and mf_pulse are 1 there. In this subclass, sync_n has no effect.
- R5: With cfg_subclass = 2, a low-to-high transition of sync_n realigns the counters in the same way. That transition never sets phase_err. In this subclass, sysref has no effect.
- R6: With cfg_subclass = 0 or 3, the counters run free from reset, and both sysref and sync_n have no effect. locked is 1 from the second cycle after reset is released.
- R7: ref_mode[1] = 1 selects one-shot handling. Only the first accepted sysref edge after reset, or after a rearm pulse, realigns the counters. Later edges are ignored until the next rearm. A one-shot realignment never sets phase_err.
- R8: ref_mode = 0 selects periodic handling and ref_mode = 1 selects gapped handling. In both, an accepted sysref edge that lands on any cycle other than the last octet of a multi-frame sets phase_err, and the counters still realign. An edge that lands on the last octet leaves phase_err unchanged. phase_err stays set until reset or until a rearm pulse, which clears it on the following cycle.
- R9: locked rises in the cycle after the first accepted alignment edge. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; one cycle per octet |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_octets_m1 | input | OCT_W | Octets per frame minus one |
| cfg_frames_m1 | input | FRM_W | Frames per multi-frame minus one |
| cfg_subclass | input | 2 | 0/3 free-run, 1 align to sysref, 2 align to sync_n release |
| ref_mode | input | 2 | 0 periodic, 1 gapped, 2 or 3 one-shot |
| rearm | input | 1 | Re-arms one-shot capture and clears phase_err |
| sysref | input | 1 | Reference strobe, already in the clock domain |
| sync_n | input | 1 | Synchronisation request, low = requested |
| frame_pulse | output | 1 | High on the first octet of each frame |
| mf_pulse | output | 1 | High on the first octet of each multi-frame |
| locked | output | 1 | Phase has been set at least once |
| phase_err | output | 1 | Sticky flag for an out-of-step reference edge |

## Verification
The bench places reference edges both on the last octet of a multi-frame and away from it. If the design compared against the wrong point, the flag would rise on in-step edges, or it would stay quiet on edges that were out of step. In one-shot mode the bench sends a second, out-of-step edge and then a third edge after a rearm. A design that forgot to disarm would shift its phase on the second edge, and one that never re-armed would ignore the third. In each subclass, the bench toggles the input that this subclass must ignore, and it runs with F = 1 and F = 256 to catch wrap and width mistakes.

// File: rtl/mf_clock_gen.sv
module mf_clock_gen #(
  parameter int OCT_W = 8,
  parameter int FRM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCT_W-1:0] cfg_octets_m1,
  input  logic [FRM_W-1:0] cfg_frames_m1,
  input  logic [1:0]       cfg_subclass,
  input  logic [1:0]       ref_mode,
  input  logic             rearm,
  input  logic             sysref,
  input  logic             sync_n,
  output logic             frame_pulse,
  output logic             mf_pulse,
  output logic             locked,
  output logic             phase_err
);

  logic [OCT_W-1:0] oct;
  logic [FRM_W-1:0] frm;
  logic ref_q, sync_q, armed;

  wire ref_rise  = sysref & ~ref_q;
  wire sync_rise = sync_n & ~sync_q;
  wire oneshot   = ref_mode[1];
  wire sc_ref    = (cfg_subclass == 2'd1);
  wire sc_sync   = (cfg_subclass == 2'd2);
  wire sc_free   = !(sc_ref || sc_sync);
  wire oct_last  = (oct >= cfg_octets_m1);
  wire frm_last  = (frm >= cfg_frames_m1);
  wire mf_last   = oct_last && frm_last;
  wire take_ref  = sc_ref && ref_rise && (!oneshot || armed);
  wire take_sync = sc_sync && sync_rise;
  wire align     = take_ref || take_sync;
  wire misphase  = take_ref && !oneshot && !mf_last;

  assign frame_pulse = (oct == '0);
  assign mf_pulse    = (oct == '0) && (frm == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oct       <= '0;
      frm       <= '0;
      ref_q     <= 1'b0;
      sync_q    <= 1'b1;
      armed     <= 1'b1;
      locked    <= 1'b0;
      phase_err <= 1'b0;
    end else begin
      ref_q  <= sysref;
      sync_q <= sync_n;

      if (align || oct_last) oct <= '0;
      else                   oct <= oct + 1'b1;

      if (align)         frm <= '0;
      else if (oct_last) frm <= frm_last ? '0 : frm + 1'b1;

      if (take_ref && oneshot) armed <= 1'b0;
      else if (rearm)          armed <= 1'b1;

      if (align || sc_free) locked <= 1'b1;

      if (misphase)   phase_err <= 1'b1;
      else if (rearm) phase_err <= 1'b0;
    end
  end

  assert_align_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> (frame_pulse && mf_pulse));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err && !rearm) |=> phase_err);

  assert_locked_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  assert_oneshot_noerr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && !rearm) |=> (phase_err == $past(phase_err)));

  assert_oneshot_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_ref && oneshot && !armed && !oct_last) |=> (oct == $past(oct) + 1'b1));

  assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_free && !oct_last) |=> (oct == $past(oct) + 1'b1));

endmodule

// File: tb/mf_clock_gen_bench.sv
`timescale 1ns/100ps
module mf_clock_gen_bench;

  typedef struct {
    int    cyc;
    bit    fr;
    bit    mf;
    bit    lk;
    bit    er;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_octets_m1 = 8'd3;
  logic [4:0] cfg_frames_m1 = 5'd2;
  logic [1:0] cfg_subclass = 2'd1;
  logic [1:0] ref_mode = 2'd0;
  logic       rearm = 1'b0;
  logic       sysref = 1'b0;
  logic       sync_n = 1'b1;
  logic       frame_pulse, mf_pulse, locked, phase_err;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;
  exp_t q[$];

  mf_clock_gen u_mf_clock_gen (
    .clk(clk), .rst_n(rst_n), .cfg_octets_m1(cfg_octets_m1),
    .cfg_frames_m1(cfg_frames_m1), .cfg_subclass(cfg_subclass),
    .ref_mode(ref_mode), .rearm(rearm), .sysref(sysref), .sync_n(sync_n),
    .frame_pulse(frame_pulse), .mf_pulse(mf_pulse), .locked(locked),
    .phase_err(phase_err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic at_cyc(input int c);
    do @(negedge clk); while (cyc < c);
  endtask

  task automatic push_win(input int from, input int n, input int f, input int fk,
                          input int ph, input bit lk, input bit er, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int d;
      d = from + i - ph;
      e.cyc = from + i;
      e.fr  = ((d % f) == 0);
      e.mf  = ((d % fk) == 0);
      e.lk  = lk;
      e.er  = er;
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0 && q[0].cyc < cyc) void'(q.pop_front());
      if (q.size() > 0 && q[0].cyc == cyc) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (frame_pulse !== e.fr || mf_pulse !== e.mf || locked !== e.lk || phase_err !== e.er) begin
          failures++;
          $display("FAIL %s cyc=%0d actual fr/mf/lk/er=%b%b%b%b expected=%b%b%b%b",
                   e.tag, cyc, frame_pulse, mf_pulse, locked, phase_err, e.fr, e.mf, e.lk, e.er);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // subclass 1, periodic, F=4 K=3
    push_win(4, 37, 4, 12, 4, 0, 0, "R1 R2 R3 R5(sync ignored in sc1)");
    at_cyc(4);   rst_n = 1'b1;
    at_cyc(10);  sync_n = 1'b0;
    at_cyc(14);  sync_n = 1'b1;
    at_cyc(40);  push_win(41, 26, 4, 12, 41, 1, 1, "R4 R8 R9 misaligned periodic");
                 sysref = 1'b1;
    at_cyc(50);  sysref = 1'b0;
    at_cyc(70);  push_win(71, 30, 4, 12, 41, 1, 0, "R8 rearm clears, aligned edge no error");
                 rearm = 1'b1;
    at_cyc(71);  rearm = 1'b0;
    at_cyc(76);  sysref = 1'b1;
    at_cyc(80);  sysref = 1'b0;
    at_cyc(85);  ref_mode = 2'd1;
    at_cyc(101); push_win(102, 24, 4, 12, 102, 1, 1, "R8 gapped misaligned");
                 sysref = 1'b1;
    at_cyc(105); sysref = 1'b0;
    // one-shot
    at_cyc(130); rst_n = 1'b0; ref_mode = 2'd2;
                 push_win(134, 7, 4, 12, 134, 0, 0, "R1 R9 reset clears flags");
    at_cyc(134); rst_n = 1'b1;
    at_cyc(140); push_win(141, 40, 4, 12, 141, 1, 0, "R7 first edge aligns, second ignored");
                 sysref = 1'b1;
    at_cyc(145); sysref = 1'b0;
    at_cyc(150); sysref = 1'b1;
    at_cyc(155); sysref = 1'b0;
    at_cyc(172); rearm = 1'b1;
    at_cyc(173); rearm = 1'b0;
    at_cyc(180); push_win(181, 20, 4, 12, 181, 1, 0, "R7 rearmed edge aligns");
                 sysref = 1'b1;
    at_cyc(185); sysref = 1'b0;
    // subclass 2
    at_cyc(205); rst_n = 1'b0; cfg_subclass = 2'd2; ref_mode = 2'd0;
                 push_win(209, 27, 4, 12, 209, 0, 0, "R5 sysref ignored in sc2");
    at_cyc(209); rst_n = 1'b1;
    at_cyc(215); sysref = 1'b1;
    at_cyc(220); sysref = 1'b0;
    at_cyc(225); sync_n = 1'b0;
    at_cyc(235); push_win(236, 24, 4, 12, 236, 1, 0, "R5 R9 sync release aligns");
                 sync_n = 1'b1;
    // subclass 0, F=3 K=2
    at_cyc(265); rst_n = 1'b0; cfg_subclass = 2'd0; cfg_octets_m1 = 8'd2; cfg_frames_m1 = 5'd1;
                 push_win(269, 1, 3, 6, 269, 0, 0, "R1 R6");
                 push_win(270, 40, 3, 6, 269, 1, 0, "R6 R2 R3 free run");
    at_cyc(269); rst_n = 1'b1;
    at_cyc(280); sysref = 1'b1;
    at_cyc(285); sysref = 1'b0;
    at_cyc(290); sync_n = 1'b0;
    at_cyc(295); sync_n = 1'b1;
    // F=1 K=32
    at_cyc(315); rst_n = 1'b0; cfg_octets_m1 = 8'd0; cfg_frames_m1 = 5'd31;
                 push_win(320, 70, 1, 32, 319, 1, 0, "R2 R3 F=1 K=32");
    at_cyc(319); rst_n = 1'b1;
    // F=256 K=2
    at_cyc(395); rst_n = 1'b0; cfg_octets_m1 = 8'd255; cfg_frames_m1 = 5'd1;
                 push_win(400, 601, 256, 512, 399, 1, 0, "R2 R3 F=256 K=2");
    at_cyc(399); rst_n = 1'b1;
    at_cyc(1010);
    done = 1'b1;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule